// File: doc/BRIEF.md
# Serial Boot Loader Sequencer

This block is the control sequencer of a serial boot loader. It starts once the UART bit rate has been calibrated. It then exchanges bytes with a host through a byte-wide receive and transmit interface. The host opens with a sync byte, which the sequencer acknowledges. The host then sends a 16-bit program length, most significant byte first, and after it the program bytes. The sequencer echoes every byte it receives back to the host as verification data. Each program byte is written to the next address of a RAM load window.

When the last program byte has been written, the sequencer asks a flash model whether the user area is blank. If the area is not blank, it requests a full erase. If the erase fails, it sends a single error byte and stops for good. If the area was blank or the erase succeeded, it sends a final acknowledge byte and raises a start-execution output together with the entry address of the load window.

The transmitter contract is fixed. `tx_busy` must go high in the cycle after a `tx_load` pulse and stay high until the byte has left the line. The RAM port and the flash port use a level request that the sequencer holds until a one-cycle acknowledge arrives.

Top module: `boot_seq_top`

## Requirements
- R1: While `cal_done` is low, received bytes are discarded and nothing is transmitted. Once `cal_done` is high, a received 0x55 is answered with one transmitted 0xAA.
- R2: While waiting for the sync byte, any byte other than 0x55 is dropped. It causes no transmission, and a later 0x55 is still answered with 0xAA.
- R3: The two bytes after the handshake form the program length, upper byte first. Each length byte is echoed unchanged and in arrival order. For example, 0x01 then 0x00 means 256 bytes.
- R4: Program byte i (counting from 0) is echoed and written to RAM address 0xFF300+i with its received value. The request, address and data stay stable until `ram_ack`.
- R5: A length of 0, or a length above 3072, raises `halt`. The sequencer then makes no RAM write and no flash request, and echoes no later byte.
- R6: A length of exactly 3072 is accepted, and its final write goes to address 0xFFEFF.
- R7: `tx_load` is pulsed only while the transmitter is not busy. A byte that arrives during an echo is held and processed afterwards, in order.
- R8: After the last RAM write is acknowledged, exactly one blank check is requested. A blank result (`chk_blank`=1) leads to no erase request.
- R9: A non-blank result leads to one erase request. When the erase succeeds (`ers_ok`=1), 0xAA is sent and execution starts.
- R10: A failed erase (`ers_ok`=0) sends exactly one 0xFF byte and then raises `halt`. `exec_start` never rises, and later received bytes cause no transmission.
- R11: `exec_start` rises only after the final 0xAA has been fully transmitted. It then stays high, with `exec_addr` equal to 0xFF300.
- R12: After reset, `tx_load`, `ram_req`, `chk_req`, `ers_req`, `exec_start` and `halt` are all low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| cal_done | input | 1 | Bit-rate calibration finished; the sequence may start |
| rx_valid | input | 1 | One-cycle strobe: a received byte is on `rx_byte` |
| rx_byte | input | 8 | Received byte |
| tx_busy | input | 1 | Transmitter is shifting a byte out |
| tx_load | output | 1 | One-cycle strobe: start sending `tx_byte` |
| tx_byte | output | 8 | Byte to transmit |
| ram_req | output | 1 | RAM write request, held until acknowledged |
| ram_addr | output | AW (20) | RAM write address |
| ram_wdata | output | 8 | RAM write data |
| ram_ack | input | 1 | RAM write done |
| chk_req | output | 1 | Flash blank-check request |
| chk_ack | input | 1 | Blank check done |
| chk_blank | input | 1 | Every user-area location reads 0xFF (valid with `chk_ack`) |
| ers_req | output | 1 | Full flash erase request |
| ers_ack | input | 1 | Erase finished |
| ers_ok | input | 1 | Erase succeeded (valid with `ers_ack`) |
| exec_start | output | 1 | Hand off execution to the loaded program |
| exec_addr | output | AW (20) | Entry address of the loaded program |
| halt | output | 1 | Sequencer stopped on a rejected length or a failed erase |

## Verification
The assertions check, on every cycle, the rules that are local in time:
- a load is never issued to a busy transmitter;
- RAM requests stay stable and inside the load window;
- the blank-check and erase requests are never raised together;
- the start output stays high once raised and carries the window base;
- a halted sequencer is silent and never starts execution.

Only the bench scenarios can show the rules that depend on whole sequences:
- the handshake that ignores stray bytes;
- the upper-then-lower length order and the echo order;
- the rejection of lengths 0 and 3073 against the acceptance of 3072;
- the choice between skipping the erase, erasing and reporting an erase failure.

// File: rtl/boot_pkg.sv
// Package: shared state encoding and protocol byte values for the boot loader
// sequencer. Assumes nothing beyond byte-wide UART data.
package boot_pkg;

    typedef enum logic [3:0] {
        ST_IDLE      = 4'd0,
        ST_SYNC      = 4'd1,
        ST_ACK       = 4'd2,
        ST_LEN_HI    = 4'd3,
        ST_LEN_LO    = 4'd4,
        ST_LEN_CHK   = 4'd5,
        ST_DATA      = 4'd6,
        ST_WRITE     = 4'd7,
        ST_CHECK     = 4'd8,
        ST_ERASE     = 4'd9,
        ST_FIN_TX    = 4'd10,
        ST_FIN_WAIT  = 4'd11,
        ST_RUN       = 4'd12,
        ST_FAIL_TX   = 4'd13,
        ST_FAIL_WAIT = 4'd14,
        ST_HALT      = 4'd15
    } seq_state_t;

    localparam logic [7:0] SYNC_BYTE = 8'h55;
    localparam logic [7:0] ACK_BYTE  = 8'hAA;
    localparam logic [7:0] FAIL_BYTE = 8'hFF;

endpackage

// File: rtl/boot_rx_hold.sv
// Module: one-byte receive holding register.
// Captures each received byte. The sequencer frees the register with 'take'.
// A new byte arriving in the same cycle as 'take' wins and stays valid.
// Assumes the host does not send two bytes while one is still held
// (the echo pacing of the protocol guarantees this).
module boot_rx_hold (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       rx_valid,
    input  logic [7:0] rx_byte,
    input  logic       take,
    output logic       hold_vld,
    output logic [7:0] hold_data
);

    // Purpose: latch incoming byte, clear on consumption.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            hold_vld  <= 1'b0;
            hold_data <= 8'h00;
        end else if (rx_valid) begin
            hold_vld  <= 1'b1;
            hold_data <= rx_byte;
        end else if (take) begin
            hold_vld  <= 1'b0;
        end
    end

endmodule

// File: rtl/boot_tx_gate.sv
// Module: transmit issue stage.
// Registers one byte for the serializer and reports when a new byte may be
// issued. Assumes the serializer raises tx_busy in the cycle after tx_load.
// The registered load flag covers that one-cycle gap.
module boot_tx_gate (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       send,
    input  logic [7:0] send_val,
    input  logic       tx_busy,
    output logic       tx_load,
    output logic [7:0] tx_byte,
    output logic       tx_idle
);

    logic       load_q;
    logic [7:0] byte_q;

    // Purpose: register the load strobe and its byte.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            load_q <= 1'b0;
            byte_q <= 8'h00;
        end else begin
            load_q <= send;
            if (send) begin
                byte_q <= send_val;
            end
        end
    end

    // Purpose: idle only when no byte is shifting and none was just loaded.
    always_comb begin
        tx_idle = !tx_busy && !load_q;
    end

    assign tx_load = load_q;
    assign tx_byte = byte_q;

endmodule

// File: rtl/boot_len_addr.sv
// Module: length register, remaining-byte counter and load-address generator.
// The upper length byte is stored first. The lower byte completes the length
// and restarts the address index at zero. Each acknowledged write decrements
// the remaining count and advances the index.
// Assumes that 'step' is never given while the remaining count is zero.
module boot_len_addr #(
    parameter int          LW      = 16,
    parameter int          AW      = 20,
    parameter logic [AW-1:0] BASE  = 20'hFF300,
    parameter int          MAX_LEN = 3072
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          ld_hi,
    input  logic          ld_lo,
    input  logic          step,
    input  logic [7:0]    byte_in,
    output logic          len_bad,
    output logic          last,
    output logic [AW-1:0] addr
);

    localparam int          HW     = LW - 8;
    localparam logic [LW-1:0] MAX_V = LW'(MAX_LEN);
    localparam logic [LW-1:0] ONE_V = LW'(1);

    logic [HW-1:0] hi_q;
    logic [LW-1:0] remain_q;
    logic [LW-1:0] idx_q;

    // Purpose: assemble the length, upper byte first.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            hi_q <= '0;
        end else if (ld_hi) begin
            hi_q <= HW'(byte_in);
        end
    end

    // Purpose: track remaining bytes and the write index.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            remain_q <= '0;
            idx_q    <= '0;
        end else if (ld_lo) begin
            remain_q <= {hi_q, byte_in};
            idx_q    <= '0;
        end else if (step) begin
            remain_q <= remain_q - ONE_V;
            idx_q    <= idx_q + ONE_V;
        end
    end

    // Purpose: length validity, last-byte flag and the write address.
    always_comb begin
        len_bad = (remain_q == '0) || (remain_q > MAX_V);
        last    = (remain_q == ONE_V);
        addr    = BASE + AW'(idx_q);
    end

endmodule

// File: rtl/boot_seq_top.sv
// Module: serial boot loader sequencer (top).
// Runs after bit-rate calibration:
//   1. sync handshake;
//   2. length reception, upper byte first;
//   3. program reception, with an echo of every byte;
//   4. sequential RAM writes;
//   5. flash blank check and erase if needed;
//   6. final acknowledge, then start of execution, or the error byte and a
//      halt on a failed erase.
// Assumptions: tx_busy rises the cycle after tx_load. RAM and flash ports
// hold their request until a one-cycle acknowledge, and chk_blank and ers_ok
// are valid together with their acknowledge.
module boot_seq_top #(
    parameter int            AW      = 20,
    parameter int            LW      = 16,
    parameter logic [AW-1:0] BASE    = 20'hFF300,
    parameter int            MAX_LEN = 3072
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          cal_done,
    input  logic          rx_valid,
    input  logic [7:0]    rx_byte,
    input  logic          tx_busy,
    output logic          tx_load,
    output logic [7:0]    tx_byte,
    output logic          ram_req,
    output logic [AW-1:0] ram_addr,
    output logic [7:0]    ram_wdata,
    input  logic          ram_ack,
    output logic          chk_req,
    input  logic          chk_ack,
    input  logic          chk_blank,
    output logic          ers_req,
    input  logic          ers_ack,
    input  logic          ers_ok,
    output logic          exec_start,
    output logic [AW-1:0] exec_addr,
    output logic          halt
);
    import boot_pkg::*;

    seq_state_t st, nxt;

    logic       hold_vld;
    logic [7:0] hold_data;
    logic       take;
    logic       send;
    logic [7:0] send_val;
    logic       tx_idle;
    logic       ld_hi, ld_lo, step, cap;
    logic       len_bad, last;
    logic [7:0] wdata_q;

    boot_rx_hold u_rx (
        .clk       (clk),
        .rst_n     (rst_n),
        .rx_valid  (rx_valid),
        .rx_byte   (rx_byte),
        .take      (take),
        .hold_vld  (hold_vld),
        .hold_data (hold_data)
    );

    boot_tx_gate u_tx (
        .clk      (clk),
        .rst_n    (rst_n),
        .send     (send),
        .send_val (send_val),
        .tx_busy  (tx_busy),
        .tx_load  (tx_load),
        .tx_byte  (tx_byte),
        .tx_idle  (tx_idle)
    );

    boot_len_addr #(
        .LW      (LW),
        .AW      (AW),
        .BASE    (BASE),
        .MAX_LEN (MAX_LEN)
    ) u_len (
        .clk     (clk),
        .rst_n   (rst_n),
        .ld_hi   (ld_hi),
        .ld_lo   (ld_lo),
        .step    (step),
        .byte_in (hold_data),
        .len_bad (len_bad),
        .last    (last),
        .addr    (ram_addr)
    );

    // Purpose: state register.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st <= ST_IDLE;
        end else begin
            st <= nxt;
        end
    end

    // Purpose: capture the program byte presented to RAM.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            wdata_q <= 8'h00;
        end else if (cap) begin
            wdata_q <= hold_data;
        end
    end

    // Purpose: next-state and per-cycle control strobes.
    always_comb begin
        nxt      = st;
        take     = 1'b0;
        send     = 1'b0;
        send_val = 8'h00;
        ld_hi    = 1'b0;
        ld_lo    = 1'b0;
        step     = 1'b0;
        cap      = 1'b0;
        case (st)
            ST_IDLE: begin
                take = hold_vld;
                if (cal_done) nxt = ST_SYNC;
            end
            ST_SYNC: begin
                if (hold_vld && tx_idle) begin
                    take = 1'b1;
                    if (hold_data == SYNC_BYTE) nxt = ST_ACK;
                end
            end
            ST_ACK: begin
                if (tx_idle) begin
                    send     = 1'b1;
                    send_val = ACK_BYTE;
                    nxt      = ST_LEN_HI;
                end
            end
            ST_LEN_HI: begin
                if (hold_vld && tx_idle) begin
                    take     = 1'b1;
                    send     = 1'b1;
                    send_val = hold_data;
                    ld_hi    = 1'b1;
                    nxt      = ST_LEN_LO;
                end
            end
            ST_LEN_LO: begin
                if (hold_vld && tx_idle) begin
                    take     = 1'b1;
                    send     = 1'b1;
                    send_val = hold_data;
                    ld_lo    = 1'b1;
                    nxt      = ST_LEN_CHK;
                end
            end
            ST_LEN_CHK: begin
                nxt = len_bad ? ST_HALT : ST_DATA;
            end
            ST_DATA: begin
                if (hold_vld && tx_idle) begin
                    take     = 1'b1;
                    send     = 1'b1;
                    send_val = hold_data;
                    cap      = 1'b1;
                    nxt      = ST_WRITE;
                end
            end
            ST_WRITE: begin
                if (ram_ack) begin
                    step = 1'b1;
                    nxt  = last ? ST_CHECK : ST_DATA;
                end
            end
            ST_CHECK: begin
                if (chk_ack) nxt = chk_blank ? ST_FIN_TX : ST_ERASE;
            end
            ST_ERASE: begin
                if (ers_ack) nxt = ers_ok ? ST_FIN_TX : ST_FAIL_TX;
            end
            ST_FIN_TX: begin
                if (tx_idle) begin
                    send     = 1'b1;
                    send_val = ACK_BYTE;
                    nxt      = ST_FIN_WAIT;
                end
            end
            ST_FIN_WAIT: begin
                if (tx_idle) nxt = ST_RUN;
            end
            ST_RUN: begin
                take = hold_vld;
            end
            ST_FAIL_TX: begin
                if (tx_idle) begin
                    send     = 1'b1;
                    send_val = FAIL_BYTE;
                    nxt      = ST_FAIL_WAIT;
                end
            end
            ST_FAIL_WAIT: begin
                if (tx_idle) nxt = ST_HALT;
            end
            ST_HALT: begin
                take = hold_vld;
            end
            default: nxt = ST_IDLE;
        endcase
    end

    // Purpose: state-decoded outputs toward RAM, flash and the CPU.
    always_comb begin
        ram_req    = (st == ST_WRITE);
        ram_wdata  = wdata_q;
        chk_req    = (st == ST_CHECK);
        ers_req    = (st == ST_ERASE);
        exec_start = (st == ST_RUN);
        exec_addr  = BASE;
        halt       = (st == ST_HALT);
    end

endmodule

// File: rtl/boot_seq_chk.sv
// Module: assertion checker for boot_seq_top, attached with bind.
// Observes ports only.
module boot_seq_chk #(
    parameter int            AW      = 20,
    parameter logic [AW-1:0] BASE    = 20'hFF300,
    parameter int            MAX_LEN = 3072
) (
    input logic          clk,
    input logic          rst_n,
    input logic          tx_busy,
    input logic          tx_load,
    input logic          ram_req,
    input logic [AW-1:0] ram_addr,
    input logic [7:0]    ram_wdata,
    input logic          ram_ack,
    input logic          chk_req,
    input logic          ers_req,
    input logic          exec_start,
    input logic [AW-1:0] exec_addr,
    input logic          halt
);

    localparam logic [AW-1:0] LAST_ADDR = BASE + AW'(MAX_LEN - 1);

    p_tx_idle_r7: assert property (@(posedge clk) disable iff (!rst_n)
        tx_load |-> !tx_busy);

    p_ram_hold_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (ram_req && !ram_ack) |=> (ram_req && $stable(ram_addr) && $stable(ram_wdata)));

    p_ram_window_r6: assert property (@(posedge clk) disable iff (!rst_n)
        ram_req |-> (ram_addr >= BASE && ram_addr <= LAST_ADDR));

    p_flash_excl_r8: assert property (@(posedge clk) disable iff (!rst_n)
        !(chk_req && ers_req));

    p_exec_addr_r11: assert property (@(posedge clk) disable iff (!rst_n)
        exec_start |-> (exec_addr == BASE));

    p_exec_sticky_r11: assert property (@(posedge clk) disable iff (!rst_n)
        exec_start |=> exec_start);

    p_halt_quiet_r10: assert property (@(posedge clk) disable iff (!rst_n)
        halt |-> (!tx_load && !ram_req && !exec_start && !chk_req && !ers_req));

    p_halt_sticky_r5: assert property (@(posedge clk) disable iff (!rst_n)
        halt |=> halt);

endmodule

bind boot_seq_top boot_seq_chk #(
    .AW      (AW),
    .BASE    (BASE),
    .MAX_LEN (MAX_LEN)
) u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .tx_busy    (tx_busy),
    .tx_load    (tx_load),
    .ram_req    (ram_req),
    .ram_addr   (ram_addr),
    .ram_wdata  (ram_wdata),
    .ram_ack    (ram_ack),
    .chk_req    (chk_req),
    .ers_req    (ers_req),
    .exec_start (exec_start),
    .exec_addr  (exec_addr),
    .halt       (halt)
);

// File: tb/sim_boot_seq_top.sv
// Bench: directed scenarios for boot_seq_top. It has a transmitter model,
// a RAM model with write checking and a flash model.
module sim_boot_seq_top;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        cal_done = 1'b0;
    logic        rx_valid = 1'b0;
    logic [7:0]  rx_byte = 8'h00;
    logic        tx_busy;
    logic        tx_load;
    logic [7:0]  tx_byte;
    logic        ram_req;
    logic [19:0] ram_addr;
    logic [7:0]  ram_wdata;
    logic        ram_ack;
    logic        chk_req;
    logic        chk_ack;
    logic        chk_blank;
    logic        ers_req;
    logic        ers_ack;
    logic        ers_ok;
    logic        exec_start;
    logic [19:0] exec_addr;
    logic        halt;

    int checks = 0;
    int failures = 0;
    bit done = 0;

    logic        blank_v = 1'b1;
    logic        ok_v = 1'b1;

    always #2 clk = ~clk;

    boot_seq_top u0 (
        .clk(clk), .rst_n(rst_n), .cal_done(cal_done),
        .rx_valid(rx_valid), .rx_byte(rx_byte),
        .tx_busy(tx_busy), .tx_load(tx_load), .tx_byte(tx_byte),
        .ram_req(ram_req), .ram_addr(ram_addr), .ram_wdata(ram_wdata), .ram_ack(ram_ack),
        .chk_req(chk_req), .chk_ack(chk_ack), .chk_blank(chk_blank),
        .ers_req(ers_req), .ers_ack(ers_ack), .ers_ok(ers_ok),
        .exec_start(exec_start), .exec_addr(exec_addr), .halt(halt)
    );

    function automatic logic [7:0] pat(int i);
        return 8'((i * 37 + 5) & 255);
    endfunction

    // Transmitter model: busy for 6 cycles after each load, logs bytes.
    logic [7:0] tx_log [4096];
    int tx_cnt;
    int busy_cnt;
    assign tx_busy = (busy_cnt != 0);
    always @(posedge clk) begin
        if (!rst_n) begin
            tx_cnt   <= 0;
            busy_cnt <= 0;
        end else if (tx_load) begin
            if (tx_cnt < 4096) tx_log[tx_cnt] <= tx_byte;
            tx_cnt   <= tx_cnt + 1;
            busy_cnt <= 6;
        end else if (busy_cnt > 0) begin
            busy_cnt <= busy_cnt - 1;
        end
    end

    // RAM model: acknowledges after 2 waiting cycles and checks address and data.
    int ram_wait, wr_cnt, wr_bad;
    logic [19:0] first_addr, last_addr;
    always @(posedge clk) begin
        if (!rst_n) begin
            ram_ack <= 1'b0; ram_wait <= 0; wr_cnt <= 0; wr_bad <= 0;
            first_addr <= '0; last_addr <= '0;
        end else if (ram_req && !ram_ack) begin
            if (ram_wait == 2) begin
                ram_ack  <= 1'b1;
                ram_wait <= 0;
                if (ram_addr != 20'hFF300 + 20'(wr_cnt) || ram_wdata != pat(wr_cnt))
                    wr_bad <= wr_bad + 1;
                if (wr_cnt == 0) first_addr <= ram_addr;
                last_addr <= ram_addr;
                wr_cnt <= wr_cnt + 1;
            end else begin
                ram_wait <= ram_wait + 1;
            end
        end else begin
            ram_ack <= 1'b0;
        end
    end

    // Flash model: blank check and erase, each acknowledged after 3 cycles.
    int chk_wait, ers_wait, chk_cnt, ers_cnt;
    assign chk_blank = blank_v;
    assign ers_ok = ok_v;
    always @(posedge clk) begin
        if (!rst_n) begin
            chk_ack <= 1'b0; ers_ack <= 1'b0;
            chk_wait <= 0; ers_wait <= 0; chk_cnt <= 0; ers_cnt <= 0;
        end else begin
            chk_ack <= 1'b0;
            ers_ack <= 1'b0;
            if (chk_req && !chk_ack) begin
                if (chk_wait == 3) begin
                    chk_ack <= 1'b1; chk_wait <= 0; chk_cnt <= chk_cnt + 1;
                end else chk_wait <= chk_wait + 1;
            end
            if (ers_req && !ers_ack) begin
                if (ers_wait == 3) begin
                    ers_ack <= 1'b1; ers_wait <= 0; ers_cnt <= ers_cnt + 1;
                end else ers_wait <= ers_wait + 1;
            end
        end
    end

    task automatic check(input bit ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            failures++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic boot_reset(input logic blank, input logic ok);
        @(negedge clk);
        rst_n = 1'b0; cal_done = 1'b0; rx_valid = 1'b0;
        blank_v = blank; ok_v = ok;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
    endtask

    task automatic put(input logic [7:0] b, input int gap);
        rx_valid = 1'b1; rx_byte = b;
        @(negedge clk);
        rx_valid = 1'b0;
        repeat (gap) @(negedge clk);
    endtask

    // Handshake plus length, with the length bytes sent back to back.
    task automatic open_session(input logic [7:0] hi, input logic [7:0] lo);
        cal_done = 1'b1;
        @(negedge clk);
        put(8'h55, 14);
        put(hi, 0);
        put(lo, 20);
    endtask

    task automatic send_prog(input int n);
        for (int i = 0; i < n; i++) put(pat(i), 14);
        repeat (60) @(negedge clk);
    endtask

    task automatic t_reset;
        boot_reset(1'b1, 1'b1);
        check(!tx_load && !ram_req && !chk_req && !ers_req && !exec_start && !halt,
              "R12 outputs after reset",
              {tx_load, ram_req, chk_req, ers_req, exec_start, halt}, 0);
    endtask

    task automatic t_normal;
        boot_reset(1'b1, 1'b1);
        put(8'h55, 14);
        check(tx_cnt == 0, "R1 no answer before cal_done", tx_cnt, 0);
        cal_done = 1'b1;
        @(negedge clk);
        put(8'h12, 14);
        put(8'hAA, 14);
        check(tx_cnt == 0, "R2 stray bytes ignored", tx_cnt, 0);
        put(8'h55, 14);
        check(tx_cnt == 1 && tx_log[0] == 8'hAA, "R1 sync answered 0xAA", tx_log[0], 8'hAA);
        put(8'h00, 0);
        put(8'h04, 20);
        check(tx_log[1] == 8'h00 && tx_log[2] == 8'h04, "R3 R7 length echoed in order",
              {tx_log[1], tx_log[2]}, 16'h0004);
        send_prog(4);
        for (int i = 0; i < 4; i++)
            check(tx_log[3+i] == pat(i), "R4 program byte echo", tx_log[3+i], pat(i));
        check(wr_cnt == 4 && wr_bad == 0 && first_addr == 20'hFF300,
              "R4 RAM writes", wr_cnt, 4);
        check(chk_cnt == 1 && ers_cnt == 0, "R8 one check no erase", ers_cnt, 0);
        check(tx_cnt == 8 && tx_log[7] == 8'hAA, "R11 final ack", tx_log[7], 8'hAA);
        check(exec_start && exec_addr == 20'hFF300 && !halt, "R11 exec start",
              exec_addr, 20'hFF300);
    endtask

    task automatic t_erase_ok;
        boot_reset(1'b0, 1'b1);
        open_session(8'h01, 8'h00);
        check(tx_log[1] == 8'h01 && tx_log[2] == 8'h00, "R3 256 upper first",
              {tx_log[1], tx_log[2]}, 16'h0100);
        send_prog(256);
        check(wr_cnt == 256 && wr_bad == 0 && last_addr == 20'hFF3FF,
              "R4 256 writes", last_addr, 20'hFF3FF);
        check(chk_cnt == 1 && ers_cnt == 1, "R9 one erase", ers_cnt, 1);
        check(tx_cnt == 260 && tx_log[259] == 8'hAA && exec_start,
              "R9 ack then exec", tx_cnt, 260);
    endtask

    task automatic t_erase_fail;
        boot_reset(1'b0, 1'b0);
        open_session(8'h00, 8'h02);
        send_prog(2);
        check(ers_cnt == 1, "R10 erase tried", ers_cnt, 1);
        check(tx_cnt == 6 && tx_log[5] == 8'hFF, "R10 single 0xFF", tx_log[5], 8'hFF);
        check(halt && !exec_start, "R10 halted no exec", {halt, exec_start}, 2);
        put(8'h55, 20);
        check(tx_cnt == 6, "R10 silent after halt", tx_cnt, 6);
    endtask

    task automatic t_len_bad(input logic [7:0] hi, input logic [7:0] lo);
        boot_reset(1'b1, 1'b1);
        open_session(hi, lo);
        check(halt && tx_cnt == 3, "R5 rejected length halts", tx_cnt, 3);
        put(8'h11, 20);
        check(wr_cnt == 0 && chk_cnt == 0 && tx_cnt == 3 && !exec_start,
              "R5 no write no echo", wr_cnt, 0);
    endtask

    task automatic t_max;
        boot_reset(1'b1, 1'b1);
        open_session(8'h0C, 8'h00);
        send_prog(3072);
        check(wr_cnt == 3072 && wr_bad == 0, "R6 3072 writes", wr_cnt, 3072);
        check(last_addr == 20'hFFEFF, "R6 last address", last_addr, 20'hFFEFF);
        check(exec_start && !halt, "R6 exec after max", exec_start, 1);
    endtask

    task automatic finish_run;
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            checks++;
            failures++;
            $display("FAIL watchdog expired");
            finish_run();
        end
    end

    initial begin
        t_reset();
        t_normal();
        t_erase_ok();
        t_erase_fail();
        t_len_bad(8'h00, 8'h00);
        t_len_bad(8'h0C, 8'h01);
        t_max();
        done = 1;
        finish_run();
    end

endmodule